// File: doc/BRIEF.md
# OTP Programming-Mode Access Front End

This block sits between the programming pins of a small microcontroller and its one-time-programmable (OTP) storage. The same eight address pins carry two bytes in turn. First they carry the upper half of a 16-bit address, which is captured when the address-latch strobe falls. Then they carry the lower half, which is used live. A two-bit access-mode select is captured when the latch strobe rises. It steers each access to one of three targets: an OTP byte array, a pair of fixed identification bytes, or a small protection-level register.

A read strobe and a program strobe, both active low, start each access. A read drives the data port, modelled as a data value plus an output enable. A program access fires once, on the falling edge of the program strobe. Programming only clears bits, and the protection level can only rise. Once the protection level is non-zero, the array is hidden and can no longer be programmed.

All pins are sampled on the block clock. Accesses are allowed only while the chip reset pin is held low and the programming-mode select is high. If the mode select moves while the latch strobe is high, the block raises a sticky protocol error that stops all further accesses.

Top module: `otp_prog_if`

## Requirements
- R1: Accesses are allowed only while `devRstN`=0 and `progSel`=1. At any other time `dataOe` stays 0 and program strobes change nothing.
- R2: The value on `addrIn` in the first clock where `aleIn` is seen low after being high becomes address bits 15:8. Bits 7:0 come from the live `addrIn`.
- R3: `modeSel` is captured in the clock where `aleIn` is first seen high. Its encoding is 00 reserved, 01 identification bytes, 10 protection level, 11 OTP array.
- R4: If `modeSel` differs from the captured mode while `aleIn` stays high, a sticky error is set. While the error is set, no access happens (`dataOe`=0, no writes). The error clears while `devRstN`=1 or `porN`=0.
- R5: While an access is allowed and `rdN`=0, `dataOe`=1 and `dataOut` carries the addressed byte. Otherwise `dataOe`=0.
- R6: In OTP mode, each high-to-low edge of `prgN` writes stored = stored AND `dataIn`, once per edge.
- R7: In identification mode, a read returns `VER0` when address bit 0 is 0 and `VER1` when it is 1. Writes have no effect.
- R8: In protection mode, a read returns the level in the low `LOCK_W` bits with zeros above. A write ORs `dataIn[LOCK_W-1:0]` into the level, so the level never falls.
- R9: While the level is non-zero, OTP reads return 0xFF and OTP writes are refused.
- R10: Reserved mode reads return 0xFF, and writes in that mode have no effect.
- R11: OTP addresses at or above `MEM_DEPTH` read 0xFF, and writes to them have no effect.
- R12: While `porN`=0, every array byte becomes 0xFF, the level becomes 0 and the error flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; every pin is sampled on its rising edge |
| porN | input | 1 | Power-on initialisation of the storage model, active low |
| devRstN | input | 1 | Chip reset pin; must be 0 while programming |
| progSel | input | 1 | Programming-mode select, active high |
| modeSel | input | 2 | Access-mode select |
| aleIn | input | 1 | Address-latch strobe |
| addrIn | input | 8 | Multiplexed address pins |
| rdN | input | 1 | Read strobe, active low |
| prgN | input | 1 | Program strobe, active low |
| dataIn | input | 8 | Data presented for programming |
| dataOut | output | 8 | Read data |
| dataOe | output | 1 | Read data drive enable |

## Verification
The hardest state to reach from the pins is the one that combines a latched upper address byte, an OTP mode and a non-zero protection level. Random programming would push the protection level up within a few accesses and hide the array from every later check. The random phase therefore only reads the protection register; it programs the OTP array, the identification bytes and reserved addresses, including out-of-range upper bytes. Directed sequences then raise the level, break the mode-select ordering while the latch strobe is high, and try accesses with the chip reset and mode select inactive.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

  typedef enum logic [1:0] {
    MODE_RSVD = 2'b00,
    MODE_VER  = 2'b01,
    MODE_LOCK = 2'b10,
    MODE_OTP  = 2'b11
  } accMode_e;

  typedef struct packed {
    logic     captureHi;
    logic     rdEn;
    logic     wrOtp;
    logic     wrLock;
    accMode_e mode;
  } ctrlStrobe_t;

endpackage

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_prog_pkg::*;
(
  input  logic        clk,
  input  logic        porN,
  input  logic        devRstN,
  input  logic        progSel,
  input  logic [1:0]  modeSel,
  input  logic        aleIn,
  input  logic        rdN,
  input  logic        prgN,
  output ctrlStrobe_t strobe,
  output logic        protoErr
);

  logic     aleQ;
  logic     prgQ;
  accMode_e modeLat;
  logic     aleRise;
  logic     aleFall;
  logic     prgFall;
  logic     accessOk;
  logic     modeSlip;

  assign aleRise  = aleIn && !aleQ;
  assign aleFall  = !aleIn && aleQ;
  assign prgFall  = !prgN && prgQ;
  assign modeSlip = aleIn && aleQ && (modeSel != modeLat);
  assign accessOk = !devRstN && progSel && !protoErr;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      aleQ    <= 1'b0;
      prgQ    <= 1'b1;
      modeLat <= MODE_RSVD;
    end else begin
      aleQ <= aleIn;
      prgQ <= prgN;
      if (aleRise) modeLat <= accMode_e'(modeSel);
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      protoErr <= 1'b0;
    end else if (devRstN) begin
      protoErr <= 1'b0;
    end else if (modeSlip) begin
      protoErr <= 1'b1;
    end
  end

  always_comb begin
    strobe.captureHi = aleFall;
    strobe.mode      = modeLat;
    strobe.rdEn      = accessOk && !rdN;
    strobe.wrOtp     = accessOk && prgFall && (modeLat == MODE_OTP);
    strobe.wrLock    = accessOk && prgFall && (modeLat == MODE_LOCK);
  end

  AST_MODE_HELD_OFF_RISE: assert property (@(posedge clk) disable iff (!porN)
    !aleRise |=> $stable(modeLat)); // R3

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!porN)
    (protoErr && !devRstN) |=> protoErr); // R4

  AST_RESET_PIN_BLOCKS: assert property (@(posedge clk) disable iff (!porN)
    devRstN |-> !(strobe.rdEn || strobe.wrOtp || strobe.wrLock)); // R1

endmodule

// File: rtl/otp_prog_dp.sv
module otp_prog_dp
  import otp_prog_pkg::*;
#(
  parameter int          PIN_W     = 8,
  parameter int          DATA_W    = 8,
  parameter int          MEM_DEPTH = 256,
  parameter int          LOCK_W    = 2,
  parameter logic [7:0]  VER0      = 8'hC5,
  parameter logic [7:0]  VER1      = 8'h3A
) (
  input  logic              clk,
  input  logic              porN,
  input  ctrlStrobe_t       strobe,
  input  logic [PIN_W-1:0]  addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);

  localparam int ADDR_W = 2 * PIN_W;
  localparam int IDX_W  = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [PIN_W-1:0]  addrHi;
  logic [ADDR_W-1:0] addrFull;
  logic [IDX_W-1:0]  memIdx;
  logic              inRange;
  logic [LOCK_W-1:0] lockLvl;
  logic [DATA_W-1:0] memArr [MEM_DEPTH];

  assign addrFull = {addrHi, addrIn};
  assign memIdx   = addrFull[IDX_W-1:0];
  assign inRange  = ({1'b0, addrFull} < (ADDR_W+1)'(MEM_DEPTH));

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) addrHi <= '0;
    else if (strobe.captureHi) addrHi <= addrIn;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) lockLvl <= '0;
    else if (strobe.wrLock) lockLvl <= lockLvl | dataIn[LOCK_W-1:0];
  end

  generate
    for (genvar gi = 0; gi < MEM_DEPTH; gi++) begin : g_cell
      always_ff @(posedge clk or negedge porN) begin
        if (!porN) begin
          memArr[gi] <= ALL_ONES;
        end else if (strobe.wrOtp && inRange && (lockLvl == '0)
                     && (memIdx == IDX_W'(gi))) begin
          memArr[gi] <= memArr[gi] & dataIn;
        end
      end
    end
  endgenerate

  always_comb begin
    dataOut = ALL_ONES;
    unique case (strobe.mode)
      MODE_RSVD: dataOut = ALL_ONES;
      MODE_VER:  dataOut = addrFull[0] ? DATA_W'(VER1) : DATA_W'(VER0);
      MODE_LOCK: dataOut = DATA_W'(lockLvl);
      MODE_OTP:  dataOut = (inRange && lockLvl == '0) ? memArr[memIdx] : ALL_ONES;
    endcase
  end

  AST_LOCK_NEVER_FALLS: assert property (@(posedge clk) disable iff (!porN)
    ($past(lockLvl) & ~lockLvl) == '0); // R8

  AST_HI_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!porN)
    !strobe.captureHi |=> $stable(addrHi)); // R2

endmodule

// File: rtl/otp_prog_if.sv
module otp_prog_if
  import otp_prog_pkg::*;
#(
  parameter int          PIN_W     = 8,
  parameter int          DATA_W    = 8,
  parameter int          MEM_DEPTH = 256,
  parameter int          LOCK_W    = 2,
  parameter logic [7:0]  VER0      = 8'hC5,
  parameter logic [7:0]  VER1      = 8'h3A
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              devRstN,
  input  logic              progSel,
  input  logic [1:0]        modeSel,
  input  logic              aleIn,
  input  logic [PIN_W-1:0]  addrIn,
  input  logic              rdN,
  input  logic              prgN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  ctrlStrobe_t strobe;
  logic        protoErr;

  otp_prog_ctrl ctrl_i (
    .clk      (clk),
    .porN     (porN),
    .devRstN  (devRstN),
    .progSel  (progSel),
    .modeSel  (modeSel),
    .aleIn    (aleIn),
    .rdN      (rdN),
    .prgN     (prgN),
    .strobe   (strobe),
    .protoErr (protoErr)
  );

  otp_prog_dp #(
    .PIN_W     (PIN_W),
    .DATA_W    (DATA_W),
    .MEM_DEPTH (MEM_DEPTH),
    .LOCK_W    (LOCK_W),
    .VER0      (VER0),
    .VER1      (VER1)
  ) dp_i (
    .clk     (clk),
    .porN    (porN),
    .strobe  (strobe),
    .addrIn  (addrIn),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

  assign dataOe = strobe.rdEn;

  AST_ERR_BLOCKS_READ: assert property (@(posedge clk) disable iff (!porN)
    protoErr |-> !dataOe); // R4

  AST_OE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!porN)
    rdN |-> !dataOe); // R5

endmodule

// File: tb/otp_prog_if_tb_top.sv
`timescale 1ns/1ps
module otp_prog_if_tb_top;

  localparam int DEPTH = 256;
  localparam logic [7:0] V0 = 8'hC5;
  localparam logic [7:0] V1 = 8'h3A;

  logic       clk = 1'b0;
  logic       porN, devRstN, progSel, aleIn, rdN, prgN;
  logic [1:0] modeSel;
  logic [7:0] addrIn, dataIn, dataOut;
  logic       dataOe;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] mdl [DEPTH];
  logic [1:0] lockM;

  always #2.5 clk = ~clk;

  otp_prog_if dut_i (
    .clk(clk), .porN(porN), .devRstN(devRstN), .progSel(progSel),
    .modeSel(modeSel), .aleIn(aleIn), .addrIn(addrIn), .rdN(rdN),
    .prgN(prgN), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [8:0] got, logic [8:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got oe/data=%h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] expRead(logic [1:0] m, logic [15:0] a);
    case (m)
      2'b00: return 8'hFF;
      2'b01: return a[0] ? V1 : V0;
      2'b10: return {6'b0, lockM};
      default: return (a < 16'(DEPTH) && lockM == 2'b0) ? mdl[a[7:0]] : 8'hFF;
    endcase
  endfunction

  task automatic setup(logic [1:0] m, logic [15:0] a);
    modeSel = m; aleIn = 1'b0; step();
    aleIn = 1'b1; step();
    aleIn = 1'b0; addrIn = a[15:8]; step();
    addrIn = a[7:0]; step();
  endtask

  task automatic doRead(string req, logic [1:0] m, logic [15:0] a, logic expOe);
    setup(m, a);
    rdN = 1'b0;
    @(negedge clk);
    check(req, {dataOe, expOe ? dataOut : 8'h00},
          {expOe, expOe ? expRead(m, a) : 8'h00});
    step(); rdN = 1'b1; step();
  endtask

  task automatic doWrite(logic [1:0] m, logic [15:0] a, logic [7:0] d, logic live);
    setup(m, a);
    dataIn = d; prgN = 1'b0; step(); step();
    prgN = 1'b1; step();
    if (live) begin
      if (m == 2'b11 && a < 16'(DEPTH) && lockM == 2'b0) mdl[a[7:0]] = mdl[a[7:0]] & d;
      if (m == 2'b10) lockM = lockM | d[1:0];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    porN = 1'b0; devRstN = 1'b0; progSel = 1'b1; aleIn = 1'b0; rdN = 1'b1;
    prgN = 1'b1; modeSel = 2'b00; addrIn = 8'h00; dataIn = 8'h00;
    for (int i = 0; i < DEPTH; i++) mdl[i] = 8'hFF;
    lockM = 2'b0;
    step(); step(); porN = 1'b1; step();

    // R12 R5 reset state, no drive while idle
    @(negedge clk); check("R5", {dataOe, 8'h00}, 9'h000);
    doRead("R12", 2'b11, 16'h0042, 1'b1);
    doRead("R12", 2'b10, 16'h0000, 1'b1);

    // R6 directed clear-only programming
    doWrite(2'b11, 16'h0010, 8'hF0, 1'b1);
    doWrite(2'b11, 16'h0010, 8'h3F, 1'b1);
    doRead("R6", 2'b11, 16'h0010, 1'b1);
    // R2 upper byte: address 0x0110 is out of range, 0x0010 in range
    doRead("R2", 2'b11, 16'h0110, 1'b1);
    // R7 identification bytes, writes ignored
    doWrite(2'b01, 16'h0001, 8'h00, 1'b1);
    doRead("R7", 2'b01, 16'h0000, 1'b1);
    doRead("R7", 2'b01, 16'h0001, 1'b1);
    // R10 reserved
    doWrite(2'b00, 16'h0010, 8'h00, 1'b1);
    doRead("R10", 2'b00, 16'h0010, 1'b1);
    doRead("R10", 2'b11, 16'h0010, 1'b1);
    // R11 out of range write must not alias index 0x20
    doWrite(2'b11, 16'h0120, 8'h00, 1'b1);
    doRead("R11", 2'b11, 16'h0020, 1'b1);
    doRead("R11", 2'b11, 16'h0120, 1'b1);

    // R3 constrained random
    for (int k = 0; k < 400; k++) begin
      logic [1:0]  m = 2'($urandom_range(0, 3));
      logic [15:0] a = {($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00, 8'($urandom)};
      if ($urandom_range(0, 1) == 0 && m != 2'b10)
        doWrite(m, a, 8'($urandom), 1'b1);
      doRead("R3", m, a, 1'b1);
    end

    // R1 chip reset pin high: no drive, no write
    devRstN = 1'b1;
    doRead("R1", 2'b11, 16'h0030, 1'b0);
    doWrite(2'b11, 16'h0030, 8'h00, 1'b0);
    devRstN = 1'b0; progSel = 1'b0;
    doRead("R1", 2'b11, 16'h0030, 1'b0);
    doWrite(2'b11, 16'h0030, 8'h00, 1'b0);
    progSel = 1'b1;
    doRead("R1", 2'b11, 16'h0030, 1'b1);

    // R4 mode moves while latch strobe high
    modeSel = 2'b11; aleIn = 1'b1; step(); step();
    modeSel = 2'b10; step(); aleIn = 1'b0; step();
    doRead("R4", 2'b11, 16'h0031, 1'b0);
    doWrite(2'b11, 16'h0031, 8'h00, 1'b0);
    devRstN = 1'b1; step(); devRstN = 1'b0; step();
    doRead("R4", 2'b11, 16'h0031, 1'b1);

    // R8 R9 protection level
    doWrite(2'b10, 16'h0000, 8'h00, 1'b1);
    doRead("R8", 2'b10, 16'h0000, 1'b1);
    doWrite(2'b10, 16'h0000, 8'h01, 1'b1);
    doWrite(2'b10, 16'h0000, 8'hFC, 1'b1);
    doRead("R8", 2'b10, 16'h0000, 1'b1);
    doRead("R9", 2'b11, 16'h0010, 1'b1);
    doWrite(2'b11, 16'h0011, 8'h00, 1'b1);
    doRead("R9", 2'b11, 16'h0011, 1'b1);

    // R12 power-on clears level and array
    porN = 1'b0; step(); porN = 1'b1; step();
    for (int i = 0; i < DEPTH; i++) mdl[i] = 8'hFF;
    lockM = 2'b0;
    doRead("R12", 2'b11, 16'h0010, 1'b1);
    doRead("R12", 2'b10, 16'h0000, 1'b1);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule